// File: doc/BRIEF.md
# Counter-Synchronized Wait Execution Unit

This execution unit carries out a "wait until the system counter reaches a deadline" instruction for a small processor core. The core issues one decoded instruction word together with the current value of the destination register (the deadline) and the value of the source register. The unit then holds the core stalled while it watches a shared, free-running 32-bit system counter, and releases only when the counter has been exactly equal to the deadline.

On release the unit adds a delta to the deadline. The delta is either the source register value or a zero-extended 9-bit literal taken from the instruction. The sum is written back to the destination register, so that a loop of such waits stays locked to the first deadline rather than to the time each instruction was issued. The unit can also update a zero flag and a carry flag from that addition. A minimum occupancy of six cycles is enforced even when the deadline has already arrived at issue.

Top module: `cntwait_unit`

## Requirements
- R1: An issue is accepted only when the unit is idle, the instruction opcode (bits 31:26) is 6'b111110 and the condition field (bits 21:18) is 4'b1111; any other issue leaves busy low and produces no completion.
- R2: busy rises in the cycle after an accepted issue and stays high through the completion cycle, then falls; done is a single-cycle pulse that only occurs while busy is high.
- R3: Completion (done high) never comes earlier than the sixth cycle after the issue edge, and comes exactly then when the counter equals the deadline at issue.
- R4: Release requires that the system counter was exactly equal to the deadline on some clock edge since issue; a counter already past the deadline keeps the unit waiting until the count comes round to the deadline again.
- R5: In the completion cycle wr_data equals deadline plus delta modulo 2^32 and wr_addr equals the destination field, instruction bits 17:9.
- R6: When instruction bit 22 is 1 the delta is instruction bits 8:0 zero-extended to 32 bits; when it is 0 the delta is src_val.
- R7: wr_en pulses together with done only when instruction bit 23 (write result) is 1; otherwise no write occurs.
- R8: When instruction bit 25 is 1, flag_z takes the value (sum == 0) at completion; otherwise flag_z keeps its previous value.
- R9: When instruction bit 24 is 1, flag_c takes the unsigned carry out of the 32-bit addition at completion; otherwise flag_c keeps its previous value.
- R10: A synchronous active-high reset clears busy, done, wr_en, flag_z and flag_c, abandoning any wait in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Unit clock |
| rst | input | 1 | Synchronous reset, active high |
| issue | input | 1 | Issue strobe for the instruction on instr |
| instr | input | 32 | Instruction word with opcode, effect bits, condition and register fields |
| tgt_val | input | 32 | Current value of the destination register (the deadline) |
| src_val | input | 32 | Current value of the source register |
| sys_cnt | input | 32 | Shared free-running system counter, synchronous to clk |
| busy | output | 1 | Core stall request |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Destination register write enable |
| wr_addr | output | 9 | Destination register index |
| wr_data | output | 32 | Advanced deadline written back |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |

## Verification
The hardest situation to reach is a deadline that has already been passed at issue, since a real counter would need about four billion cycles to come round again. The bench drives the counter as an offset plus a running tick, so it can place the count just beyond the deadline at issue, hold the unit waiting for a few hundred cycles, then jump the count to just below the deadline to stand in for the wrap. The carry and zero corner cases are reached the same way, by loading the counter with 0 or all ones before issuing.

// File: rtl/cntwait_pkg.sv
package cntwait_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned REG_W   = 9;
  localparam logic [5:0]  OPC_WAIT = 6'b111110;
  localparam logic [3:0]  COND_ALWAYS = 4'b1111;

  // Instruction word layout; the field order is decoded by the unit.
  typedef struct packed {
    logic [5:0]       opc;
    logic             eff_z;
    logic             eff_c;
    logic             eff_r;
    logic             imm;
    logic [3:0]       cond;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
  } instr_t;

  // Operation captured at issue.
  typedef struct packed {
    logic [DATA_W-1:0] target;
    logic [DATA_W-1:0] delta;
    logic [REG_W-1:0]  dst;
    logic              eff_z;
    logic              eff_c;
    logic              eff_r;
  } op_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_WB   = 2'd2
  } state_t;

  function automatic logic [DATA_W:0] add_carry(input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic is_zero(input logic [DATA_W-1:0] v);
    return v == '0;
  endfunction

  function automatic logic [DATA_W-1:0] zext_lit(input logic [REG_W-1:0] lit);
    return {{(DATA_W-REG_W){1'b0}}, lit};
  endfunction

endpackage

// File: rtl/cntwait_decode.sv
module cntwait_decode
  import cntwait_pkg::*;
(
  input  logic              issue,
  input  logic              idle,
  input  logic [DATA_W-1:0] instr,
  input  logic [DATA_W-1:0] tgt_val,
  input  logic [DATA_W-1:0] src_val,
  output logic              accept,
  output op_t               op
);

  instr_t iw;
  logic   opc_ok;
  logic   cond_ok;

  always_comb begin
    iw      = instr_t'(instr);
    opc_ok  = (iw.opc == OPC_WAIT);
    cond_ok = (iw.cond == COND_ALWAYS);
    accept  = issue && idle && opc_ok && cond_ok;

    op.target = tgt_val;
    op.delta  = iw.imm ? zext_lit(iw.src) : src_val;
    op.dst    = iw.dst;
    op.eff_z  = iw.eff_z;
    op.eff_c  = iw.eff_c;
    op.eff_r  = iw.eff_r;
  end

endmodule

// File: rtl/cntwait_timer.sv
module cntwait_timer
  import cntwait_pkg::*;
#(
  parameter int unsigned MIN_CYC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] start_tgt,
  input  logic [DATA_W-1:0] sys_cnt,
  output logic              busy,
  output logic              fire,
  output logic [DATA_W-1:0] tgt_q
);

  localparam int unsigned EW       = (MIN_CYC > 2) ? $clog2(MIN_CYC) : 1;
  localparam int unsigned ELAP_MAX = (MIN_CYC > 2) ? MIN_CYC - 2 : 0;

  state_t        state_q;
  logic [EW-1:0] elap_q;
  logic          hit_q;
  logic          match_now;
  logic          min_met;

  assign match_now = (sys_cnt == tgt_q);
  assign min_met   = (elap_q >= EW'(ELAP_MAX));
  assign fire      = (state_q == ST_WAIT) && (hit_q || match_now) && min_met;
  assign busy      = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      elap_q  <= '0;
      hit_q   <= 1'b0;
      tgt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_WAIT;
            elap_q  <= '0;
            hit_q   <= (sys_cnt == start_tgt);
            tgt_q   <= start_tgt;
          end
        end
        ST_WAIT: begin
          if (fire) begin
            state_q <= ST_WB;
          end else begin
            if (!min_met) elap_q <= elap_q + 1'b1;
            if (match_now) hit_q <= 1'b1;
          end
        end
        ST_WB:   state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Checker-side edge counter since issue, saturating.
  logic [EW:0] chk_edges;
  always_ff @(posedge clk) begin
    if (rst) chk_edges <= '0;
    else if (start && !busy) chk_edges <= (EW+1)'(1);
    else if (busy && chk_edges < (EW+1)'(MIN_CYC)) chk_edges <= chk_edges + 1'b1;
  end

  p_min_latency_r3: assert property (@(posedge clk) disable iff (rst)
    fire |-> chk_edges >= (EW+1)'(MIN_CYC - 1));

  p_wb_single_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WB) |=> (state_q == ST_IDLE));

  p_target_held_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |=> $stable(tgt_q));

endmodule

// File: rtl/cntwait_result.sv
module cntwait_result
  import cntwait_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  op_t               op_in,
  input  logic              fire,
  input  logic [DATA_W-1:0] target,
  output logic              done,
  output logic              wr_en,
  output logic [REG_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              flag_z,
  output logic              flag_c
);

  op_t             op_q;
  logic [DATA_W:0] sum_c;

  assign sum_c = add_carry(target, op_q.delta);

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= '0;
    end else if (start) begin
      op_q <= op_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done    <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      flag_z  <= 1'b0;
      flag_c  <= 1'b0;
    end else if (fire) begin
      done    <= 1'b1;
      wr_en   <= op_q.eff_r;
      wr_addr <= op_q.dst;
      wr_data <= sum_c[DATA_W-1:0];
      if (op_q.eff_z) flag_z <= is_zero(sum_c[DATA_W-1:0]);
      if (op_q.eff_c) flag_c <= sum_c[DATA_W];
    end else begin
      done  <= 1'b0;
      wr_en <= 1'b0;
    end
  end

  p_z_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(flag_z));

  p_c_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(flag_c));

  p_z_value_r8: assert property (@(posedge clk) disable iff (rst)
    (fire && op_q.eff_z) |=> (flag_z == (wr_data == '0)));

  p_c_value_r9: assert property (@(posedge clk) disable iff (rst)
    (fire && op_q.eff_c) |=> (flag_c == (wr_data < $past(target))));

endmodule

// File: rtl/cntwait_unit.sv
module cntwait_unit
  import cntwait_pkg::*;
#(
  parameter int unsigned MIN_CYC = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [31:0]       instr,
  input  logic [31:0]       tgt_val,
  input  logic [31:0]       src_val,
  input  logic [31:0]       sys_cnt,
  output logic              busy,
  output logic              done,
  output logic              wr_en,
  output logic [8:0]        wr_addr,
  output logic [31:0]       wr_data,
  output logic              flag_z,
  output logic              flag_c
);

  logic              accept;
  logic              fire;
  op_t               op_dec;
  logic [DATA_W-1:0] tgt_cur;

  cntwait_decode u_dec (
    .issue   (issue),
    .idle    (!busy),
    .instr   (instr),
    .tgt_val (tgt_val),
    .src_val (src_val),
    .accept  (accept),
    .op      (op_dec)
  );

  cntwait_timer #(.MIN_CYC(MIN_CYC)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .start_tgt (op_dec.target),
    .sys_cnt   (sys_cnt),
    .busy      (busy),
    .fire      (fire),
    .tgt_q     (tgt_cur)
  );

  cntwait_result u_res (
    .clk     (clk),
    .rst     (rst),
    .start   (accept),
    .op_in   (op_dec),
    .fire    (fire),
    .target  (tgt_cur),
    .done    (done),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .flag_z  (flag_z),
    .flag_c  (flag_c)
  );

  p_accept_gate_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(issue && instr[31:26] == OPC_WAIT && instr[21:18] == COND_ALWAYS));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_busy_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> busy);

  p_write_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> done);

endmodule

// File: tb/tb_cntwait_unit.sv
module tb_cntwait_unit;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst, issue;
  logic [31:0] instr, tgt_val, src_val;
  logic [31:0] tick = 32'd0;
  logic [31:0] cnt_off = 32'd0;
  wire  [31:0] sys_cnt = cnt_off + tick;
  logic        busy, done, wr_en, flag_z, flag_c;
  logic [8:0]  wr_addr;
  logic [31:0] wr_data;

  always @(posedge clk) tick <= tick + 32'd1;

  cntwait_unit dut (
    .clk(clk), .rst(rst), .issue(issue), .instr(instr), .tgt_val(tgt_val),
    .src_val(src_val), .sys_cnt(sys_cnt), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_z(flag_z), .flag_c(flag_c)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on each rising edge.
  logic        m_busy = 0, m_wb = 0, m_done = 0, m_wr = 0, m_hit = 0, m_z = 0, m_c = 0;
  logic [31:0] m_tgt = 0, m_delta = 0, m_ins = 0, m_sum = 0;
  int          m_n = 0;
  longint      m_s;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_wb = 0; m_done = 0; m_wr = 0; m_z = 0; m_c = 0; m_sum = 0;
    end else begin
      m_done = 0; m_wr = 0;
      if (!m_busy) begin
        if (issue && instr[31:26] == 6'b111110 && instr[21:18] == 4'b1111) begin
          m_busy  = 1;
          m_n     = 0;
          m_ins   = instr;
          m_tgt   = tgt_val;
          m_hit   = (sys_cnt == tgt_val);
          m_delta = instr[22] ? {23'd0, instr[8:0]} : src_val;
        end
      end else if (m_wb) begin
        m_busy = 0; m_wb = 0;
      end else begin
        m_n++;
        if (sys_cnt == m_tgt) m_hit = 1;
        if (m_hit && m_n >= 5) begin
          m_s    = longint'(m_tgt) + longint'(m_delta);
          m_sum  = m_s[31:0];
          m_wb   = 1;
          m_done = 1;
          m_wr   = m_ins[23];
          if (m_ins[25]) m_z = (m_sum == 32'd0);
          if (m_ins[24]) m_c = m_s[32];
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 busy", {31'd0, busy}, {31'd0, m_busy});
      chk("R3 done", {31'd0, done}, {31'd0, m_done});
      chk("R7 wr_en", {31'd0, wr_en}, {31'd0, m_wr});
      if (m_done) begin
        chk("R5 wr_data", wr_data, m_sum);
        chk("R5 wr_addr", {23'd0, wr_addr}, {23'd0, m_ins[17:9]});
      end
      chk("R8 flag_z", {31'd0, flag_z}, {31'd0, m_z});
      chk("R9 flag_c", {31'd0, flag_c}, {31'd0, m_c});
    end
  end

  function automatic logic [31:0] mk(input logic z, input logic c, input logic r,
                                     input logic i, input logic [8:0] d, input logic [8:0] s);
    return {6'b111110, z, c, r, i, 4'b1111, d, s};
  endfunction

  task automatic set_cnt(input logic [31:0] v);
    cnt_off = v - tick;
  endtask

  task automatic issue_op(input logic [31:0] ins, input logic [31:0] t, input logic [31:0] s);
    issue = 1; instr = ins; tgt_val = t; src_val = s;
    @(negedge clk);
    issue = 0;
  endtask

  task automatic wait_done(input int lim, output int n);
    n = 1;
    while (!done && n < lim) begin
      @(negedge clk);
      n++;
    end
    if (!done) n = -1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  bit finished = 0;

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    int seen;
    logic [31:0] t;
    rst = 1; issue = 0; instr = 0; tgt_val = 0; src_val = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R10: reset state
    chk("R10 busy after reset", {31'd0, busy}, 0);
    chk("R10 flags after reset", {30'd0, flag_z, flag_c}, 0);

    // R3: deadline already equal at issue
    set_cnt(32'd100);
    issue_op(mk(1, 1, 1, 0, 9'd5, 9'd0), 32'd100, 32'd7);
    wait_done(100, n);
    chk("R3 latency at immediate match", n, 6);
    chk("R5 sum 100+7", wr_data, 32'd107);
    settle();

    // R4: deadline 20 ahead
    t = sys_cnt + 32'd20;
    issue_op(mk(0, 0, 1, 0, 9'd9, 9'd0), t, 32'd1000);
    wait_done(100, n);
    chk("R4 release on exact match", n, 21);
    chk("R5 advanced deadline", wr_data, t + 32'd1000);
    settle();

    // Truth table corners with both flag effects
    set_cnt(32'd0);
    issue_op(mk(1, 1, 1, 0, 9'd1, 9'd2), 32'd0, 32'd0);
    wait_done(100, n);
    chk("R8 zero sum sets Z", {31'd0, flag_z}, 1);
    chk("R9 no carry 0+0", {31'd0, flag_c}, 0);
    settle();
    set_cnt(32'hFFFF_FFFF);
    issue_op(mk(1, 1, 1, 0, 9'd1, 9'd2), 32'hFFFF_FFFF, 32'd1);
    wait_done(100, n);
    chk("R5 wraps to zero", wr_data, 32'd0);
    chk("R9 carry out", {31'd0, flag_c}, 1);
    chk("R8 Z on wrapped sum", {31'd0, flag_z}, 1);
    settle();
    set_cnt(32'd0);
    issue_op(mk(1, 1, 1, 0, 9'd1, 9'd2), 32'd0, 32'd1);
    wait_done(100, n);
    chk("R8 Z clear for 0+1", {31'd0, flag_z}, 0);
    chk("R9 C clear for 0+1", {31'd0, flag_c}, 0);
    settle();

    // R6: immediate literal zero-extended
    set_cnt(32'd1000);
    issue_op(mk(0, 0, 1, 1, 9'd3, 9'h1FF), 32'd1000, 32'hDEAD_BEEF);
    wait_done(100, n);
    chk("R6 literal delta", wr_data, 32'd1511);
    settle();
    set_cnt(32'd1000);
    issue_op(mk(0, 0, 1, 0, 9'd3, 9'h1FF), 32'd1000, 32'h10);
    wait_done(100, n);
    chk("R6 register delta", wr_data, 32'd1016);
    settle();

    // R7: no write when result bit clear
    set_cnt(32'd50);
    issue_op(mk(0, 0, 0, 0, 9'd4, 9'd0), 32'd50, 32'd3);
    wait_done(100, n);
    chk("R7 no write", {31'd0, wr_en}, 0);
    chk("R7 done still pulses", {31'd0, done}, 1);
    settle();

    // R8/R9: flags hold when effects not requested (flags are 0,0 now)
    set_cnt(32'hFFFF_FFFF);
    issue_op(mk(0, 0, 1, 0, 9'd4, 9'd0), 32'hFFFF_FFFF, 32'd1);
    wait_done(100, n);
    chk("R8 Z held", {31'd0, flag_z}, 0);
    chk("R9 C held", {31'd0, flag_c}, 0);
    settle();

    // R1: wrong opcode, wrong condition
    issue_op({6'b111111, 4'b0010, 4'b1111, 9'd1, 9'd1}, sys_cnt, 32'd1);
    chk("R1 bad opcode ignored", {31'd0, busy}, 0);
    issue_op({6'b111110, 4'b0010, 4'b0111, 9'd1, 9'd1}, sys_cnt, 32'd1);
    chk("R1 bad condition ignored", {31'd0, busy}, 0);
    settle();
    // R1: issue while busy ignored
    t = sys_cnt + 32'd30;
    issue_op(mk(0, 0, 1, 0, 9'd11, 9'd0), t, 32'd2);
    @(negedge clk);
    issue_op(mk(0, 0, 1, 0, 9'd22, 9'd0), sys_cnt, 32'd9);
    wait_done(100, n);
    chk("R1 busy issue ignored addr", {23'd0, wr_addr}, 32'd11);
    chk("R1 busy issue ignored data", wr_data, t + 32'd2);
    settle();

    // R4: deadline already passed at issue; stand in for the wrap
    set_cnt(32'd5000);
    issue_op(mk(0, 0, 1, 0, 9'd7, 9'd0), 32'd4999, 32'd4);
    seen = 0;
    repeat (300) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R4 no release past deadline", seen, 0);
    chk("R4 still stalled", {31'd0, busy}, 1);
    set_cnt(32'd4990);
    wait_done(100, n);
    chk("R4 release after wrap", {31'd0, done}, 1);
    chk("R5 wrap result", wr_data, 32'd5003);
    settle();

    // R10: reset during a wait
    t = sys_cnt + 32'd40;
    issue_op(mk(1, 1, 1, 0, 9'd6, 9'd0), t, 32'd1);
    repeat (3) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R10 busy cleared", {31'd0, busy}, 0);
    seen = 0;
    repeat (60) begin
      @(negedge clk);
      if (done) seen++;
    end
    chk("R10 wait abandoned", seen, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule